// File: doc/BRIEF.md
# Exposure-Synchronized Panel Readout Sequencer

This block produces the digital timing for reading out a flat-panel pixel array. An exposure trigger starts a frame. The block then clears the integration node and holds an integration window. After that it visits each row in turn: it enables the row, waits out a quiet settling interval, and issues the correlated-double-sampling strobes and a burst of column sample-clock enables. It emits only strobes, sync markers and row enables. The analog switches, the converter and the pixel data path are driven elsewhere from these signals.

Integration length, settle length, row count, column count and the active calibration-table selector are written into shadow registers at any time. They are copied into the working set only on the cycle that accepts a trigger, which is also the frame-start marker. Every interval inside a frame is therefore fixed for that whole frame, and the latency from trigger to integration and from trigger to readout is a constant number of cycles. A trigger that arrives while a frame is running is dropped and recorded in a sticky overrun flag.

Top module: `panel_readout_seq`

## Requirements
- R1: A frame runs in this fixed order, with exactly one of clr_strb, line_sync, cds_sig_smp, cds_base_smp or smp_clk_en high in any cycle. The order is: one clear cycle, I integration cycles, then for each row a line cycle, S settle cycles, one signal-sample cycle, one row-clear cycle (clr_strb), S settle cycles, one baseline-sample cycle and C sample-clock cycles, then one frame-end cycle.
- R2: If trig is sampled high while idle, clr_strb and frame_sync are high in the next cycle. Integration starts 2 cycles after the trigger edge, and the first line_sync comes 2+I cycles after it, on every frame.
- R3: After each row switching event (line_sync or row clear), S cycles with no strobe pass before cds_sig_smp or cds_base_smp, and row_sel does not change in between.
- R4: Each row receives one cds_sig_smp and one cds_base_smp, the baseline sample coming after the row clear.
- R5: frame_sync pulses for one cycle together with the frame clear, and again for one cycle immediately after the last sample-clock cycle of the last row.
- R6: Every row lasts exactly 2S+C+4 cycles and begins with one line_sync. row_sel is one-hot, bit r for row r (rows counted from 0), and is held from the line cycle through the row's last sample-clock cycle. row_idx equals r during that time.
- R7: A pulse on cfg_wr loads the shadow settings. The settings take effect only when a trigger is accepted. act_table shows the table selector in use and never changes while busy.
- R8: A trigger sampled while busy does not alter the running frame and sets overrun, which stays high until reset.
- R9: An integration or settle setting of 0 acts as 1, a row or column count of 0 acts as 1, and a row count above MAX_ROWS acts as MAX_ROWS.
- R10: busy is high from the cycle after trigger acceptance through the frame-end cycle and low otherwise. While idle, row_sel is all zero and smp_clk_en is low.
- R11: After reset all strobes, row_sel, busy and overrun are 0 and act_table is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trig | input | 1 | Exposure trigger, sampled each cycle |
| cfg_wr | input | 1 | Loads the cfg_* values into the shadow registers |
| cfg_int_len | input | INT_W | Integration length in cycles |
| cfg_settle | input | SET_W | Settle length in cycles |
| cfg_rows | input | ROW_W | Number of rows to read |
| cfg_cols | input | COL_W | Sample-clock cycles per row |
| cfg_table | input | TBL_W | Calibration-table selector |
| row_sel | output | MAX_ROWS | One-hot row enables |
| row_idx | output | ROW_W | Index of the current row |
| clr_strb | output | 1 | Frame clear or row clear strobe |
| cds_base_smp | output | 1 | Baseline (post-reset) sample strobe |
| cds_sig_smp | output | 1 | Signal sample strobe |
| smp_clk_en | output | 1 | Column sample-clock enable |
| frame_sync | output | 1 | Frame start and frame end marker |
| line_sync | output | 1 | Row step marker |
| busy | output | 1 | Frame in progress |
| overrun | output | 1 | Sticky flag for a trigger that arrived while busy |
| act_table | output | TBL_W | Calibration-table selector in use |

## Verification
The hardest situation to reach from the ports is a settings write or a second trigger that lands inside a running frame, including one on the frame-end cycle. The frame must keep its original timing and table, and the new settings must appear only on the next frame. The bench writes the shadow registers in the middle of a frame and fires triggers both in the middle and on the last busy cycle. It then compares every cycle of that frame and the next against a cycle-offset model computed from the old and new settings.

// File: rtl/panel_seq_pkg.sv
package panel_seq_pkg;
   typedef enum logic [3:0] {
      ST_IDLE,
      ST_CLR,
      ST_INTEG,
      ST_LINE,
      ST_SET1,
      ST_SIG,
      ST_RCLR,
      ST_SET2,
      ST_BASE,
      ST_CONV,
      ST_ENDF
   } seq_state_e;
endpackage

// File: rtl/prs_cfg_bank.sv
module prs_cfg_bank #(
   parameter int INT_W    = 16,
   parameter int SET_W    = 8,
   parameter int COL_W    = 10,
   parameter int ROW_W    = 5,
   parameter int TBL_W    = 2,
   parameter int MAX_ROWS = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr,
   input  logic             load,
   input  logic [INT_W-1:0] in_int,
   input  logic [SET_W-1:0] in_set,
   input  logic [ROW_W-1:0] in_rows,
   input  logic [COL_W-1:0] in_cols,
   input  logic [TBL_W-1:0] in_tbl,
   output logic [INT_W-1:0] a_int,
   output logic [SET_W-1:0] a_set,
   output logic [ROW_W-1:0] a_rows,
   output logic [COL_W-1:0] a_cols,
   output logic [TBL_W-1:0] a_tbl
);
   localparam logic [ROW_W-1:0] ROW_CAP = ROW_W'(MAX_ROWS);

   logic [INT_W-1:0] s_int;
   logic [SET_W-1:0] s_set;
   logic [ROW_W-1:0] s_rows;
   logic [COL_W-1:0] s_cols;
   logic [TBL_W-1:0] s_tbl;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         s_int  <= INT_W'(1);
         s_set  <= SET_W'(1);
         s_rows <= ROW_W'(1);
         s_cols <= COL_W'(1);
         s_tbl  <= '0;
      end else if (wr) begin
         s_int  <= in_int;
         s_set  <= in_set;
         s_rows <= in_rows;
         s_cols <= in_cols;
         s_tbl  <= in_tbl;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         a_int  <= INT_W'(1);
         a_set  <= SET_W'(1);
         a_rows <= ROW_W'(1);
         a_cols <= COL_W'(1);
         a_tbl  <= '0;
      end else if (load) begin
         a_int  <= (s_int == '0) ? INT_W'(1) : s_int;
         a_set  <= (s_set == '0) ? SET_W'(1) : s_set;
         a_cols <= (s_cols == '0) ? COL_W'(1) : s_cols;
         a_tbl  <= s_tbl;
         if (s_rows == '0)
            a_rows <= ROW_W'(1);
         else if (s_rows > ROW_CAP)
            a_rows <= ROW_CAP;
         else
            a_rows <= s_rows;
      end
   end
endmodule

// File: rtl/prs_seq_fsm.sv
module prs_seq_fsm
   import panel_seq_pkg::*;
#(
   parameter int INT_W = 16,
   parameter int SET_W = 8,
   parameter int COL_W = 10,
   parameter int ROW_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             trig,
   input  logic [INT_W-1:0] a_int,
   input  logic [SET_W-1:0] a_set,
   input  logic [ROW_W-1:0] a_rows,
   input  logic [COL_W-1:0] a_cols,
   output seq_state_e       state,
   output logic [ROW_W-1:0] row,
   output logic             accept,
   output logic             ovr
);
   localparam int W1    = (INT_W > SET_W) ? INT_W : SET_W;
   localparam int CNT_W = (W1 > COL_W) ? W1 : COL_W;

   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] int_m1, set_m1, col_m1;
   logic             last_row;

   assign accept   = (state == ST_IDLE) && trig;
   assign int_m1   = CNT_W'(a_int) - CNT_W'(1);
   assign set_m1   = CNT_W'(a_set) - CNT_W'(1);
   assign col_m1   = CNT_W'(a_cols) - CNT_W'(1);
   assign last_row = (row == (a_rows - ROW_W'(1)));

   always_ff @(posedge clk) begin
      if (!rst_n)
         ovr <= 1'b0;
      else if (trig && (state != ST_IDLE))
         ovr <= 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state <= ST_IDLE;
         cnt   <= '0;
         row   <= '0;
      end else begin
         unique case (state)
            ST_IDLE:  if (trig) state <= ST_CLR;
            ST_CLR: begin
               state <= ST_INTEG;
               cnt   <= int_m1;
               row   <= '0;
            end
            ST_INTEG: if (cnt == '0) state <= ST_LINE; else cnt <= cnt - 1'b1;
            ST_LINE: begin
               state <= ST_SET1;
               cnt   <= set_m1;
            end
            ST_SET1:  if (cnt == '0) state <= ST_SIG; else cnt <= cnt - 1'b1;
            ST_SIG:   state <= ST_RCLR;
            ST_RCLR: begin
               state <= ST_SET2;
               cnt   <= set_m1;
            end
            ST_SET2:  if (cnt == '0) state <= ST_BASE; else cnt <= cnt - 1'b1;
            ST_BASE: begin
               state <= ST_CONV;
               cnt   <= col_m1;
            end
            ST_CONV: begin
               if (cnt != '0)
                  cnt <= cnt - 1'b1;
               else if (last_row)
                  state <= ST_ENDF;
               else begin
                  row   <= row + 1'b1;
                  state <= ST_LINE;
               end
            end
            ST_ENDF:  state <= ST_IDLE;
            default:  state <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/prs_row_decode.sv
module prs_row_decode #(
   parameter int MAX_ROWS = 16,
   parameter int ROW_W    = 5
) (
   input  logic                en,
   input  logic [ROW_W-1:0]    idx,
   output logic [MAX_ROWS-1:0] sel
);
   for (genvar g = 0; g < MAX_ROWS; g++) begin : g_row
      assign sel[g] = en && (idx == ROW_W'(g));
   end
endmodule

// File: rtl/panel_readout_seq.sv
module panel_readout_seq
   import panel_seq_pkg::*;
#(
   parameter int MAX_ROWS = 16,
   parameter int INT_W    = 16,
   parameter int SET_W    = 8,
   parameter int COL_W    = 10,
   parameter int TBL_W    = 2,
   localparam int ROW_W   = $clog2(MAX_ROWS + 1)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                trig,
   input  logic                cfg_wr,
   input  logic [INT_W-1:0]    cfg_int_len,
   input  logic [SET_W-1:0]    cfg_settle,
   input  logic [ROW_W-1:0]    cfg_rows,
   input  logic [COL_W-1:0]    cfg_cols,
   input  logic [TBL_W-1:0]    cfg_table,
   output logic [MAX_ROWS-1:0] row_sel,
   output logic [ROW_W-1:0]    row_idx,
   output logic                clr_strb,
   output logic                cds_base_smp,
   output logic                cds_sig_smp,
   output logic                smp_clk_en,
   output logic                frame_sync,
   output logic                line_sync,
   output logic                busy,
   output logic                overrun,
   output logic [TBL_W-1:0]    act_table
);
   if (MAX_ROWS < 1) begin : g_bad_rows
      $error("MAX_ROWS must be at least 1");
   end
   if (INT_W < 1 || SET_W < 1 || COL_W < 1 || TBL_W < 1) begin : g_bad_w
      $error("all widths must be at least 1");
   end

   seq_state_e       state;
   logic             accept;
   logic             row_on;
   logic [INT_W-1:0] a_int;
   logic [SET_W-1:0] a_set;
   logic [ROW_W-1:0] a_rows;
   logic [COL_W-1:0] a_cols;

   prs_cfg_bank #(
      .INT_W(INT_W), .SET_W(SET_W), .COL_W(COL_W),
      .ROW_W(ROW_W), .TBL_W(TBL_W), .MAX_ROWS(MAX_ROWS)
   ) u_cfg (
      .clk(clk), .rst_n(rst_n), .wr(cfg_wr), .load(accept),
      .in_int(cfg_int_len), .in_set(cfg_settle), .in_rows(cfg_rows),
      .in_cols(cfg_cols), .in_tbl(cfg_table),
      .a_int(a_int), .a_set(a_set), .a_rows(a_rows),
      .a_cols(a_cols), .a_tbl(act_table)
   );

   prs_seq_fsm #(
      .INT_W(INT_W), .SET_W(SET_W), .COL_W(COL_W), .ROW_W(ROW_W)
   ) u_fsm (
      .clk(clk), .rst_n(rst_n), .trig(trig),
      .a_int(a_int), .a_set(a_set), .a_rows(a_rows), .a_cols(a_cols),
      .state(state), .row(row_idx), .accept(accept), .ovr(overrun)
   );

   assign row_on = (state == ST_LINE) || (state == ST_SET1) || (state == ST_SIG) ||
                   (state == ST_RCLR) || (state == ST_SET2) || (state == ST_BASE) ||
                   (state == ST_CONV);

   prs_row_decode #(.MAX_ROWS(MAX_ROWS), .ROW_W(ROW_W)) u_dec (
      .en(row_on), .idx(row_idx), .sel(row_sel)
   );

   assign clr_strb     = (state == ST_CLR) || (state == ST_RCLR);
   assign frame_sync   = (state == ST_CLR) || (state == ST_ENDF);
   assign line_sync    = (state == ST_LINE);
   assign cds_sig_smp  = (state == ST_SIG);
   assign cds_base_smp = (state == ST_BASE);
   assign smp_clk_en   = (state == ST_CONV);
   assign busy         = (state != ST_IDLE);
endmodule

// File: rtl/prs_checker.sv
module prs_checker #(
   parameter int MAX_ROWS = 16,
   parameter int TBL_W    = 2
) (
   input logic                clk,
   input logic                rst_n,
   input logic                trig,
   input logic [MAX_ROWS-1:0] row_sel,
   input logic                clr_strb,
   input logic                cds_base_smp,
   input logic                cds_sig_smp,
   input logic                smp_clk_en,
   input logic                frame_sync,
   input logic                line_sync,
   input logic                busy,
   input logic                overrun,
   input logic [TBL_W-1:0]    act_table
);
   AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      $countones({clr_strb, line_sync, cds_sig_smp, cds_base_smp, smp_clk_en}) <= 1); // R1
   AST_TRIG_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && trig) |=> (clr_strb && frame_sync)); // R2
   AST_QUIET_SIG: assert property (@(posedge clk) disable iff (!rst_n)
      cds_sig_smp |-> (!$past(line_sync) && !$past(clr_strb) && $stable(row_sel))); // R3
   AST_QUIET_BASE: assert property (@(posedge clk) disable iff (!rst_n)
      cds_base_smp |-> (!$past(clr_strb) && $stable(row_sel))); // R3
   AST_ROW_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(row_sel)); // R6
   AST_LINE_ROW: assert property (@(posedge clk) disable iff (!rst_n)
      line_sync |-> (row_sel != '0)); // R6
   AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> $stable(act_table)); // R7
   AST_OVR_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && trig) |=> overrun); // R8
   AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      overrun |=> overrun); // R8
   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> ((row_sel == '0) && !smp_clk_en)); // R10
endmodule

bind panel_readout_seq prs_checker #(.MAX_ROWS(MAX_ROWS), .TBL_W(TBL_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .trig(trig), .row_sel(row_sel),
   .clr_strb(clr_strb), .cds_base_smp(cds_base_smp), .cds_sig_smp(cds_sig_smp),
   .smp_clk_en(smp_clk_en), .frame_sync(frame_sync), .line_sync(line_sync),
   .busy(busy), .overrun(overrun), .act_table(act_table)
);

// File: tb/panel_readout_seq_tb.sv
module panel_readout_seq_tb;
   localparam int MR = 4, IW = 4, SW = 3, CW = 3, TW = 2;
   localparam int RW = $clog2(MR + 1);

   logic clk = 1'b0, rst_n = 1'b0, trig = 1'b0, cfg_wr = 1'b0;
   logic [IW-1:0] cfg_int_len = '0;
   logic [SW-1:0] cfg_settle = '0;
   logic [RW-1:0] cfg_rows = '0;
   logic [CW-1:0] cfg_cols = '0;
   logic [TW-1:0] cfg_table = '0;
   logic [MR-1:0] row_sel;
   logic [RW-1:0] row_idx;
   logic clr_strb, cds_base_smp, cds_sig_smp, smp_clk_en, frame_sync, line_sync, busy, overrun;
   logic [TW-1:0] act_table;

   int checks = 0, errors = 0;
   logic exp_ovr = 1'b0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   panel_readout_seq #(.MAX_ROWS(MR), .INT_W(IW), .SET_W(SW), .COL_W(CW), .TBL_W(TW)) u_dut (
      .clk(clk), .rst_n(rst_n), .trig(trig), .cfg_wr(cfg_wr),
      .cfg_int_len(cfg_int_len), .cfg_settle(cfg_settle), .cfg_rows(cfg_rows),
      .cfg_cols(cfg_cols), .cfg_table(cfg_table), .row_sel(row_sel), .row_idx(row_idx),
      .clr_strb(clr_strb), .cds_base_smp(cds_base_smp), .cds_sig_smp(cds_sig_smp),
      .smp_clk_en(smp_clk_en), .frame_sync(frame_sync), .line_sync(line_sync),
      .busy(busy), .overrun(overrun), .act_table(act_table)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic write_cfg(input int i, input int s, input int r, input int c, input int t);
      @(negedge clk);
      cfg_int_len = IW'(i); cfg_settle = SW'(s); cfg_rows = RW'(r);
      cfg_cols = CW'(c); cfg_table = TW'(t); cfg_wr = 1'b1;
      @(negedge clk);
      cfg_wr = 1'b0;
   endtask

   // Runs one frame from the shadow settings (i,s,r,c,t) and checks every cycle.
   // trig_at: cycle offset at which a stray trigger is driven (0: none, -1: last busy cycle).
   // wr_mid: write (wi..wt) into the shadow registers during the frame.
   task automatic run_frame(input int i, input int s, input int r, input int c, input int t,
                            input int trig_at, input bit wr_mid,
                            input int wi, input int ws, input int wr, input int wc, input int wt);
      int ei, es, er, ec, p, len, tg, busy_cnt;
      bit clamp;
      ei = (i == 0) ? 1 : i;
      es = (s == 0) ? 1 : s;
      er = (r == 0) ? 1 : ((r > MR) ? MR : r);
      ec = (c == 0) ? 1 : c;
      clamp = (i == 0) || (s == 0) || (r == 0) || (r > MR) || (c == 0);
      p = 2 * es + ec + 4;
      len = 2 + ei + er * p;
      tg = (trig_at == -1) ? len : trig_at;
      busy_cnt = 0;
      @(negedge clk);
      trig = 1'b1;
      for (int k = 1; k <= len + 1; k++) begin
         logic [5:0] ev, av;
         logic [MR-1:0] erow;
         bit eb;
         int ridx;
         string tag;
         @(negedge clk);
         ev = '0; erow = '0; eb = (k <= len); ridx = -1; tag = "R1";
         if (k == 1) begin ev = 6'b110000; tag = "R2"; end
         else if (k <= 1 + ei) tag = "R2";
         else if (k <= len) begin
            int tt, o;
            tt = k - 2 - ei;
            if (tt < er * p) begin
               ridx = tt / p; o = tt % p; erow = MR'(1) << ridx;
               if (o == 0) begin ev = 6'b001000; tag = "R6"; end
               else if (o <= es) tag = "R3";
               else if (o == es + 1) begin ev = 6'b000100; tag = "R4"; end
               else if (o == es + 2) ev = 6'b010000;
               else if (o <= 2 * es + 2) tag = "R3";
               else if (o == 2 * es + 3) begin ev = 6'b000010; tag = "R4"; end
               else ev = 6'b000001;
            end else begin
               ev = 6'b100000; tag = "R5";
            end
         end
         av = {frame_sync, clr_strb, line_sync, cds_sig_smp, cds_base_smp, smp_clk_en};
         chk(av == ev, tag, int'(av), int'(ev));
         chk(row_sel == erow, "R6", int'(row_sel), int'(erow));
         if (ridx >= 0) chk(int'(row_idx) == ridx, "R6", int'(row_idx), ridx);
         chk(busy == eb, "R10", int'(busy), int'(eb));
         chk(act_table == TW'(t), "R7", int'(act_table), t);
         chk(overrun == exp_ovr, "R8", int'(overrun), int'(exp_ovr));
         if (busy) busy_cnt++;
         trig = (k == tg) ? 1'b1 : 1'b0;
         if (k == tg && k <= len) exp_ovr = 1'b1;
         if (wr_mid && k == 2) begin
            cfg_int_len = IW'(wi); cfg_settle = SW'(ws); cfg_rows = RW'(wr);
            cfg_cols = CW'(wc); cfg_table = TW'(wt); cfg_wr = 1'b1;
         end else cfg_wr = 1'b0;
      end
      trig = 1'b0;
      chk(busy_cnt == len, clamp ? "R9" : "R1", busy_cnt, len);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R11 reset state
      chk(busy == 1'b0 && overrun == 1'b0, "R11", int'({busy, overrun}), 0);
      chk(row_sel == '0 && act_table == '0, "R11", int'({row_sel, act_table}), 0);
      chk({frame_sync, clr_strb, line_sync, cds_sig_smp, cds_base_smp, smp_clk_en} == '0,
          "R11", int'({frame_sync, clr_strb, line_sync}), 0);
      @(negedge clk);
      rst_n = 1'b1;
      // Sweep of settings, including R9 clamp values (0 and rows above MR)
      for (int a = 0; a < 3; a++)
         for (int b = 0; b < 3; b++)
            for (int d = 0; d < 4; d++)
               for (int e = 0; e < 2; e++) begin
                  int iv, rv, cv;
                  iv = (a == 2) ? 3 : a;
                  rv = (d == 3) ? 5 : ((d == 2) ? 3 : d);
                  cv = e * 2;
                  write_cfg(iv, b, rv, cv, (a + b + d) % 4);
                  run_frame(iv, b, rv, cv, (a + b + d) % 4, 0, 1'b0, 0, 0, 0, 0, 0);
               end
      // R8: stray trigger mid-frame, then on the last busy cycle
      write_cfg(2, 1, 2, 1, 1);
      run_frame(2, 1, 2, 1, 1, 6, 1'b0, 0, 0, 0, 0, 0);
      chk(overrun == 1'b1, "R8", int'(overrun), 1);
      run_frame(2, 1, 2, 1, 1, -1, 1'b0, 0, 0, 0, 0, 0);
      // R7: shadow write during a frame applies only to the next frame
      write_cfg(1, 2, 1, 2, 2);
      run_frame(1, 2, 1, 2, 2, 0, 1'b1, 3, 1, 2, 1, 3);
      run_frame(3, 1, 2, 1, 3, 0, 1'b0, 0, 0, 0, 0, 0);
      chk(overrun == 1'b1, "R8", int'(overrun), 1);
      done = 1'b1;
   end

   initial begin
      int cyc;
      cyc = 0;
      while (!done && cyc < 150000) begin
         @(posedge clk);
         cyc++;
      end
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
      end
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule